// File: doc/BRIEF.md
# Secure-Filtered Interrupt State Bitmap Bank

This block keeps five per-interrupt state bits (enable, pending, active, group, edge-trigger) and a two-bit non-secure permission field for every shared interrupt of an interrupt controller. The number of interrupt IDs, `NUM_IRQ`, is a multiple of 32. IDs 0 to 31 belong to per-core logic and have no storage here. Software reaches the state through a single-cycle register bus. Each request carries a secure/non-secure attribute, and every bit a request touches is filtered by that attribute, by the interrupt's group bit, and by its permission tier.

The shared interrupt lines enter on `irq_level_i`, where bit k is interrupt ID 32+k. A line whose trigger bit is set latches its pending bit on a rising edge. A line configured as level-sensitive shows up in pending reads for as long as it is high. A control word holds a one-way "single security state" flag. Once that flag is set, every access sees all bits.

Top module: `irq_state_bank`

## Requirements
- R1: After reset, all state is zero, the single-security flag is clear, and every register word reads as zero.
- R2: The address is {region[3:0], index}. In the enable, pending and active regions the register words come in pairs: regions 2/3 are enable, 4/5 are pending and 6/7 are active. Writing 1 to a bit of a set word (2, 4, 6) sets the state bit of ID index*32+bit. Writing 1 to a bit of a clear word (3, 5, 7) clears it. Writing 0 changes nothing, and both words of a pair read the same state.
- R3: A word whose IDs are all below 32, or at or above `NUM_IRQ`, reads as zero and ignores writes. This applies in every region except region 0.
- R4: A non-secure access made while the flag is clear sees an enable bit, an active-write bit or a trigger bit only if the interrupt's group bit is 1. Masked bits read 0 and are not written.
- R5: Region 9 holds the permission field. Each word covers 16 IDs, and the field of ID index*16+j sits at bits 2j+1:2j. For non-secure accesses while the flag is clear, a field value of 1 or more also opens the set-pending word (write and read). A value of 2 or more opens the clear-pending word and reads of both active words. A value of 0 gives no extra access.
- R6: Secure accesses, and any access while the flag is set, see every bit of the enable, pending, active and trigger words.
- R7: A pending read returns the pending latch ORed with (registered line level AND NOT edge-trigger).
- R8: A 0-to-1 change of a line sets the pending bit only when that ID is edge-triggered. A line that stays high sets nothing further. A rising edge wins over a clear-pending write to the same bit in the same cycle.
- R9: Region 8 is the trigger word. Each word covers 16 IDs (index*16+j). The edge flag of ID index*16+j is bit 2j+1, and even bits read as zero. A write changes only those 16 flags, each filtered as in R4.
- R10: Region 1 is the group word (ID index*32+bit). It is read and written only by secure accesses or while the flag is set. Otherwise it reads zero and ignores writes.
- R11: The permission field is read and written only by secure accesses while the flag is clear. Otherwise it reads zero and ignores writes.
- R12: Bit 0 of region 0, index 0, is the single-security flag. A secure write of 1 sets it while it is clear. Nothing but reset clears it. All other region 0 words and bits read zero.
- R13: A read request is answered in the next cycle with `rsp_valid` high and the data on `rsp_rdata`. `rsp_valid` is low in all other cycles. Regions 10 to 15 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Security attribute of the request |
| req_addr | input | 4+clog2(NUM_IRQ/16) | {region, word index} |
| req_wdata | input | 32 | Write data |
| irq_level_i | input | NUM_IRQ-32 | Shared interrupt line levels, bit k is ID 32+k |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |

## Verification
The hardest case to reach is a word in which the bits follow different rules: some IDs are open through their group bit, some only through a permission tier of 1 or 2, and some are closed. A second hard case is a line that rises in the same cycle as a clear-pending write to its bit. The stimulus first programs group words with half-word patterns. It then programs permission words that repeat all four tier values within each byte, so that non-secure set and clear writes of all ones show every rule inside one word. For the race, the line change and the bus write are driven on the same falling clock edge.

// File: rtl/irq_state_bank.sv
module irq_state_bank #(
  parameter int NUM_IRQ = 128,
  localparam int NWORDS = NUM_IRQ / 32,
  localparam int IDX_W = $clog2(2 * NWORDS),
  localparam int ADDR_W = 4 + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [NUM_IRQ-33:0] irq_level_i,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  localparam int NSPI = NUM_IRQ - 32;
  localparam int BW = IDX_W + 5;
  localparam logic [IDX_W:0] NW_L = NWORDS[IDX_W:0];

  localparam logic [3:0] RG_CTRL   = 4'd0;
  localparam logic [3:0] RG_GROUP  = 4'd1;
  localparam logic [3:0] RG_SETEN  = 4'd2;
  localparam logic [3:0] RG_CLREN  = 4'd3;
  localparam logic [3:0] RG_SETPND = 4'd4;
  localparam logic [3:0] RG_CLRPND = 4'd5;
  localparam logic [3:0] RG_SETACT = 4'd6;
  localparam logic [3:0] RG_CLRACT = 4'd7;
  localparam logic [3:0] RG_TRIG   = 4'd8;
  localparam logic [3:0] RG_NSAC   = 4'd9;

  logic [NSPI-1:0]   en_q, pend_q, act_q, grp_q, edge_q, lvl_q, pend_n;
  logic [2*NSPI-1:0] acc_q;
  logic              ds_q;

  logic [3:0]       region;
  logic [IDX_W-1:0] idx, wsel, sw;
  logic             wide, word_ok, ns_lim, wr, rd;
  logic [BW-1:0]    bb;
  logic [BW:0]      ab, ahb;

  assign region  = req_addr[ADDR_W-1:IDX_W];
  assign idx     = req_addr[IDX_W-1:0];
  assign wide    = (region == RG_TRIG) || (region == RG_NSAC);
  assign wsel    = wide ? (idx >> 1) : idx;
  assign word_ok = (wsel != '0) && ({1'b0, wsel} < NW_L);
  assign sw      = word_ok ? wsel - 1'b1 : '0;
  assign bb      = {sw, 5'b0};
  assign ab      = {sw, 6'b0};
  assign ahb     = {sw, idx[0], 5'b0};
  assign ns_lim  = !req_secure && !ds_q;
  assign wr      = req_valid && req_write;
  assign rd      = req_valid && !req_write;

  logic [31:0] en_w, pend_w, act_w, grp_w, edge_w, lvl_w;
  logic [63:0] acc_w;
  assign en_w   = en_q[bb +: 32];
  assign pend_w = pend_q[bb +: 32];
  assign act_w  = act_q[bb +: 32];
  assign grp_w  = grp_q[bb +: 32];
  assign edge_w = edge_q[bb +: 32];
  assign lvl_w  = lvl_q[bb +: 32];
  assign acc_w  = acc_q[ab +: 64];

  logic [31:0] ge1, ge2, m0, m1, m2;
  always_comb begin
    for (int j = 0; j < 32; j++) begin
      ge1[j] = |acc_w[2*j +: 2];
      ge2[j] = acc_w[2*j+1];
    end
  end

  assign m0 = !word_ok ? '0 : ns_lim ? grp_w : '1;
  assign m1 = !word_ok ? '0 : ns_lim ? (grp_w | ge1) : '1;
  assign m2 = !word_ok ? '0 : ns_lim ? (grp_w | ge2) : '1;

  logic [31:0] em, pview, trig_rd, tm, tv, acc_rd, rd_val;
  logic [15:0] eh, nv;
  assign em    = edge_w & m0;
  assign eh    = idx[0] ? em[31:16] : em[15:0];
  assign pview = pend_w | (lvl_w & ~edge_w);

  always_comb begin
    for (int j = 0; j < 16; j++) begin
      trig_rd[2*j]   = 1'b0;
      trig_rd[2*j+1] = eh[j];
      nv[j]          = req_wdata[2*j+1];
    end
  end

  assign tm     = idx[0] ? {m0[31:16], 16'h0} : {16'h0, m0[15:0]};
  assign tv     = idx[0] ? {nv, 16'h0} : {16'h0, nv};
  assign acc_rd = (req_secure && !ds_q && word_ok) ?
                  (idx[0] ? acc_w[63:32] : acc_w[31:0]) : '0;

  always_comb begin
    case (region)
      RG_CTRL:             rd_val = {31'b0, ds_q && (idx == '0)};
      RG_GROUP:            rd_val = (!ns_lim && word_ok) ? grp_w : '0;
      RG_SETEN, RG_CLREN:  rd_val = en_w & m0;
      RG_SETPND:           rd_val = pview & m1;
      RG_CLRPND:           rd_val = pview & m2;
      RG_SETACT, RG_CLRACT: rd_val = act_w & m2;
      RG_TRIG:             rd_val = trig_rd;
      RG_NSAC:             rd_val = acc_rd;
      default:             rd_val = '0;
    endcase
  end

  always_comb begin
    pend_n = pend_q;
    if (wr && region == RG_SETPND) pend_n[bb +: 32] = pend_w | (req_wdata & m1);
    if (wr && region == RG_CLRPND) pend_n[bb +: 32] = pend_w & ~(req_wdata & m2);
    pend_n = pend_n | (irq_level_i & ~lvl_q & edge_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0; pend_q <= '0; act_q <= '0; grp_q <= '0;
      edge_q <= '0; lvl_q <= '0; acc_q <= '0; ds_q <= 1'b0;
      rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      lvl_q     <= irq_level_i;
      pend_q    <= pend_n;
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_val;
      if (wr) begin
        case (region)
          RG_CTRL:   if (idx == '0 && req_secure && !ds_q && req_wdata[0]) ds_q <= 1'b1;
          RG_GROUP:  if (!ns_lim && word_ok) grp_q[bb +: 32] <= req_wdata;
          RG_SETEN:  en_q[bb +: 32]   <= en_w | (req_wdata & m0);
          RG_CLREN:  en_q[bb +: 32]   <= en_w & ~(req_wdata & m0);
          RG_SETACT: act_q[bb +: 32]  <= act_w | (req_wdata & m0);
          RG_CLRACT: act_q[bb +: 32]  <= act_w & ~(req_wdata & m0);
          RG_TRIG:   edge_q[bb +: 32] <= (edge_w & ~tm) | (tv & tm);
          RG_NSAC:   if (req_secure && !ds_q && word_ok) acc_q[ahb +: 32] <= req_wdata;
          default: ;
        endcase
      end
    end
  end

  a_r13_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  a_r13_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd));
  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ds_q |=> ds_q);
  a_r8_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
    |(irq_level_i & ~lvl_q & edge_q) |=>
      ((pend_q & $past(irq_level_i & ~lvl_q & edge_q)) == $past(irq_level_i & ~lvl_q & edge_q)));
  a_r4_ns_enable_group: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !req_secure && !ds_q && region == RG_SETEN) |=> ((en_q & ~$past(en_q) & ~grp_q) == '0));
  a_r3_internal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wsel == '0 && region != RG_CTRL) |=> ($stable(en_q) && $stable(act_q) && $stable(grp_q) && $stable(acc_q)));
  a_r11_ns_cannot_write_field: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !req_secure) |=> $stable(acc_q));
endmodule

// File: tb/tb_irq_state_bank.sv
module tb_irq_state_bank;
  localparam int NI = 128;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, req_write, req_secure;
  logic [6:0] req_addr;
  logic [31:0] req_wdata;
  logic [NI-33:0] lines;
  logic rsp_valid;
  logic [31:0] rsp_rdata;

  irq_state_bank #(.NUM_IRQ(NI)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_secure(req_secure), .req_addr(req_addr), .req_wdata(req_wdata),
    .irq_level_i(lines), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  bit m_en[NI], m_pend[NI], m_act[NI], m_grp[NI], m_edge[NI], m_lvl[NI];
  int m_acc[NI];
  bit m_ds, exp_rv;
  logic [31:0] exp_rd;
  int checks = 0, errors = 0;
  string cur_tag = "R1";

  function automatic bit ok(int i, bit s, int tier);
    if (i < 32 || i >= NI) return 1'b0;
    if (s || m_ds) return 1'b1;
    if (m_grp[i]) return 1'b1;
    if (tier == 0) return 1'b0;
    return m_acc[i] >= tier;
  endfunction

  function automatic logic [31:0] exp_read(int rg, int ix, bit s);
    logic [31:0] v = '0;
    for (int b = 0; b < 32; b++) begin
      int i = ix * 32 + b;
      case (rg)
        1: if ((s || m_ds) && i >= 32 && i < NI) v[b] = m_grp[i];
        2, 3: if (ok(i, s, 0)) v[b] = m_en[i];
        4: if (ok(i, s, 1)) v[b] = m_pend[i] | (m_lvl[i] & !m_edge[i]);
        5: if (ok(i, s, 2)) v[b] = m_pend[i] | (m_lvl[i] & !m_edge[i]);
        6, 7: if (ok(i, s, 2)) v[b] = m_act[i];
        default: ;
      endcase
    end
    if (rg == 0 && ix == 0) v[0] = m_ds;
    for (int j = 0; j < 16; j++) begin
      int i = ix * 16 + j;
      if (rg == 8 && ok(i, s, 0)) v[2*j+1] = m_edge[i];
      if (rg == 9 && s && !m_ds && i >= 32 && i < NI) v[2*j +: 2] = m_acc[i][1:0];
    end
    return v;
  endfunction

  task automatic model_write(int rg, int ix, bit s, logic [31:0] d);
    if (rg == 0 && ix == 0 && s && !m_ds && d[0]) m_ds = 1'b1;
    for (int b = 0; b < 32; b++) begin
      int i = ix * 32 + b;
      if (d[b]) begin
        case (rg)
          2: if (ok(i, s, 0)) m_en[i] = 1'b1;
          3: if (ok(i, s, 0)) m_en[i] = 1'b0;
          4: if (ok(i, s, 1)) m_pend[i] = 1'b1;
          5: if (ok(i, s, 2)) m_pend[i] = 1'b0;
          6: if (ok(i, s, 0)) m_act[i] = 1'b1;
          7: if (ok(i, s, 0)) m_act[i] = 1'b0;
          default: ;
        endcase
      end
      if (rg == 1 && (s || m_ds) && i >= 32 && i < NI) m_grp[i] = d[b];
    end
    for (int j = 0; j < 16; j++) begin
      int i = ix * 16 + j;
      if (rg == 8 && ok(i, s, 0)) m_edge[i] = d[2*j+1];
      if (rg == 9 && s && !m_ds && i >= 32 && i < NI) m_acc[i] = int'(d[2*j +: 2]);
    end
  endtask

  always @(posedge clk) begin : model
    bit eold[NI];
    if (!rst_n) begin
      for (int i = 0; i < NI; i++) begin
        m_en[i] = 0; m_pend[i] = 0; m_act[i] = 0; m_grp[i] = 0;
        m_edge[i] = 0; m_lvl[i] = 0; m_acc[i] = 0;
      end
      m_ds = 0; exp_rv = 0; exp_rd = '0;
    end else begin
      eold = m_edge;
      exp_rv = req_valid && !req_write;
      if (exp_rv) exp_rd = exp_read(int'(req_addr[6:3]), int'(req_addr[2:0]), req_secure);
      if (req_valid && req_write)
        model_write(int'(req_addr[6:3]), int'(req_addr[2:0]), req_secure, req_wdata);
      for (int i = 32; i < NI; i++) begin
        if (lines[i-32] && !m_lvl[i] && eold[i]) m_pend[i] = 1'b1;
        m_lvl[i] = lines[i-32];
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (rsp_valid !== exp_rv) begin
      errors++;
      $display("FAIL %s R13 rsp_valid got %b expected %b", cur_tag, rsp_valid, exp_rv);
    end
    if (exp_rv) begin
      checks++;
      if (rsp_rdata !== exp_rd) begin
        errors++;
        $display("FAIL %s rdata got %h expected %h", cur_tag, rsp_rdata, exp_rd);
      end
    end
  end

  task automatic op(bit w, bit s, int rg, int ix, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_secure = s;
    req_addr = {rg[3:0], ix[2:0]}; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd_region(bit s, int rg);
    for (int ix = 0; ix < 8; ix++) op(1'b0, s, rg, ix, '0);
  endtask

  task automatic rd_all(bit s);
    for (int rg = 0; rg < 16; rg++) rd_region(s, rg);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_secure = 1'b0;
    req_addr = '0; req_wdata = '0; lines = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_tag = "R1";
    rd_all(1'b1);
    cur_tag = "R13";
    rd_all(1'b0);

    cur_tag = "R2";
    for (int p = 0; p < 3; p++) begin
      op(1'b1, 1'b1, 2 + 2*p, 1, 32'hA5A5_0F0F); op(1'b0, 1'b1, 2 + 2*p, 1, '0);
      op(1'b1, 1'b1, 3 + 2*p, 1, 32'h0000_0F00); op(1'b0, 1'b1, 3 + 2*p, 1, '0);
      op(1'b1, 1'b1, 2 + 2*p, 1, 32'h0);         op(1'b0, 1'b1, 2 + 2*p, 1, '0);
      op(1'b1, 1'b1, 3 + 2*p, 1, 32'h0);         op(1'b0, 1'b1, 3 + 2*p, 1, '0);
    end

    cur_tag = "R3";
    op(1'b1, 1'b1, 2, 0, '1); op(1'b1, 1'b1, 2, 4, '1); op(1'b1, 1'b1, 6, 7, '1);
    op(1'b1, 1'b1, 1, 0, '1); op(1'b1, 1'b1, 8, 1, '1); op(1'b1, 1'b1, 9, 0, '1);
    op(1'b1, 1'b1, 12, 1, '1);
    rd_all(1'b1);

    cur_tag = "R10";
    op(1'b1, 1'b0, 1, 1, '1);
    rd_region(1'b1, 1); rd_region(1'b0, 1);
    op(1'b1, 1'b1, 1, 1, 32'h0000_FFFF);
    op(1'b1, 1'b1, 1, 2, 32'hFFFF_0000);
    op(1'b1, 1'b1, 1, 3, 32'h0F0F_0F0F);
    rd_region(1'b1, 1); rd_region(1'b0, 1);

    cur_tag = "R4";
    for (int ix = 1; ix < 4; ix++) begin
      op(1'b1, 1'b1, 3, ix, '1); op(1'b1, 1'b1, 7, ix, '1);
    end
    for (int ix = 1; ix < 4; ix++) op(1'b1, 1'b0, 2, ix, '1);
    rd_region(1'b1, 2); rd_region(1'b0, 3);
    op(1'b1, 1'b0, 3, 2, '1);
    rd_region(1'b1, 2);
    for (int ix = 1; ix < 4; ix++) op(1'b1, 1'b0, 6, ix, '1);
    rd_region(1'b1, 6); rd_region(1'b0, 7);

    cur_tag = "R11";
    op(1'b1, 1'b0, 9, 2, '1);
    rd_region(1'b1, 9);
    op(1'b1, 1'b1, 9, 2, 32'hE4E4_E4E4);
    op(1'b1, 1'b1, 9, 3, 32'h1B1B_1B1B);
    op(1'b1, 1'b1, 9, 4, 32'hFFFF_FFFF);
    op(1'b1, 1'b1, 9, 5, 32'h5555_5555);
    op(1'b1, 1'b1, 9, 6, 32'hAAAA_AAAA);
    op(1'b1, 1'b1, 9, 7, 32'h9C9C_3636);
    rd_region(1'b1, 9); rd_region(1'b0, 9);

    cur_tag = "R5";
    for (int ix = 1; ix < 4; ix++) op(1'b1, 1'b0, 4, ix, '1);
    rd_region(1'b1, 4); rd_region(1'b0, 4); rd_region(1'b0, 5);
    for (int ix = 1; ix < 4; ix++) op(1'b1, 1'b1, 4, ix, '1);
    for (int ix = 1; ix < 4; ix++) op(1'b1, 1'b0, 5, ix, '1);
    rd_region(1'b1, 5); rd_region(1'b0, 4); rd_region(1'b0, 5);
    for (int ix = 1; ix < 4; ix++) op(1'b1, 1'b1, 6, ix, '1);
    rd_region(1'b0, 6); rd_region(1'b0, 7);

    cur_tag = "R6";
    for (int ix = 1; ix < 4; ix++) begin
      op(1'b1, 1'b1, 2, ix, 32'h3C3C_C3C3); op(1'b1, 1'b1, 5, ix, '1);
    end
    rd_region(1'b1, 2); rd_region(1'b1, 5); rd_region(1'b1, 7);

    cur_tag = "R9";
    op(1'b1, 1'b1, 8, 2, 32'hAAAA_AAAA);
    op(1'b1, 1'b1, 8, 3, 32'h5555_FFFF);
    op(1'b1, 1'b0, 8, 4, '1);
    op(1'b1, 1'b0, 8, 5, '1);
    op(1'b1, 1'b1, 8, 6, 32'h0000_0002);
    rd_region(1'b1, 8); rd_region(1'b0, 8);
    op(1'b1, 1'b1, 8, 3, 32'h0000_0000);
    rd_region(1'b1, 8);

    cur_tag = "R7";
    for (int ix = 1; ix < 4; ix++) op(1'b1, 1'b1, 5, ix, '1);
    @(negedge clk); lines[100-32] = 1'b1; lines[40-32] = 1'b1;
    rd_region(1'b1, 4); rd_region(1'b0, 4); rd_region(1'b1, 5);

    cur_tag = "R8";
    repeat (3) @(negedge clk);
    op(1'b1, 1'b1, 5, 1, '1);
    rd_region(1'b1, 4);
    @(negedge clk); lines = '0;
    rd_region(1'b1, 4);
    @(negedge clk); lines[40-32] = 1'b1; lines[60-32] = 1'b1;
    rd_region(1'b1, 4);
    @(negedge clk); lines = '0;
    @(negedge clk);
    lines[41-32] = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_secure = 1'b1;
    req_addr = {4'd5, 3'd1}; req_wdata = '1;
    @(negedge clk); req_valid = 1'b0;
    rd_region(1'b1, 4);

    cur_tag = "R12";
    op(1'b1, 1'b0, 0, 0, 32'h1);
    rd_region(1'b1, 0);
    op(1'b1, 1'b1, 0, 1, 32'h1);
    rd_region(1'b0, 0);
    op(1'b1, 1'b1, 0, 0, 32'h1);
    rd_region(1'b0, 0);
    op(1'b1, 1'b1, 0, 0, 32'h0);
    rd_region(1'b1, 0);
    rd_region(1'b0, 1); rd_region(1'b1, 9);
    op(1'b1, 1'b1, 9, 2, '0);
    op(1'b1, 1'b0, 1, 2, 32'h1234_5678);
    for (int ix = 1; ix < 4; ix++) op(1'b1, 1'b0, 2, ix, '1);
    rd_all(1'b0);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule